// File: doc/BRIEF.md
# Recirculating Serial Delay Register

This block is a fixed-length serial delay line of 64 single-bit stages. A select input chooses where the next bit comes from: an external serial data input or a loop-back input. The loop-back input is normally tied to the main output, so the register turns into a closed 64-bit ring. On every rising clock edge the chosen bit enters the first stage, and every stored bit advances by one position. The bit that leaves the last stage drives the main output and its inverse.

For chaining several registers, the block offers two extras. A trailing half-stage re-captures the main output on the falling edge, so a downstream register can sample it with comfortable margin when clock edges are slow. A copy of the input clock is also brought out so that a downstream register can be clocked from it.

The register is fully static. With the clock parked high or low, no stored bit changes. A synchronous clear empties the chain so that simulation starts from a known state. The asynchronous reset is applied at once and released in step with the clock.

Top module: `recirc_delay_reg`

## Requirements
- R1: A bit taken into stage 1 on a rising edge appears on `q_out` after exactly 64 rising edges counted from, and including, that edge.
- R2: With `mode_sel` = 0 the bit from `din_ext` enters stage 1, and `din_loop` has no effect. With `mode_sel` = 1 the bit from `din_loop` enters stage 1, and `din_ext` has no effect.
- R3: `q_out_n` is always the inverse of `q_out`.
- R4: `q_half` takes the value of `q_out` on each falling clock edge and holds it until the next falling edge.
- R5: While the clock stays at a constant level (high or low), `q_out`, `q_out_n` and `q_half` do not change, whatever the data and select inputs do.
- R6: `clk_pass` follows `clk` with no added cycle of delay.
- R7: With `clr` = 1 on a rising edge, every stage becomes 0 on that edge. With `clr` = 1 on a falling edge, `q_half` becomes 0 on that edge.
- R8: While `rst_n` = 0, all stages and the half-stage are 0 without waiting for a clock edge. After release, the register shifts normally.
- R9: With `din_loop` tied to `q_out` and `mode_sel` = 1, the output sequence repeats with a period of 64 rising edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock; stages advance on the rising edge, the half-stage on the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| clr | input | 1 | Synchronous active-high clear of all stages and the half-stage |
| mode_sel | input | 1 | Source select for stage 1: 0 = external data, 1 = loop-back |
| din_ext | input | 1 | External serial data input |
| din_loop | input | 1 | Loop-back serial input, normally tied to `q_out` |
| q_out | output | 1 | Last-stage output |
| q_out_n | output | 1 | Inverse of the last-stage output |
| q_half | output | 1 | Last-stage value re-captured on the falling edge |
| clk_pass | output | 1 | Clock copy for clocking a downstream register |

## Verification
In ring mode, the bit leaving stage 64 is also the bit entering stage 1 on the same rising edge. The read of the old tail and the write of the new head therefore fall in one cycle. The bench provokes this by tying `din_loop` to `q_out` after loading a known pattern. It judges the result against a behavioural queue model and by comparing each output bit with the bit 64 edges earlier. A clear that lands while a full chain of ones is shifting is judged the same way: the very next output must be 0, and so must the half-stage at the falling edge that follows.

// File: rtl/recirc_pkg.sv
package recirc_pkg;

  // Number of full stages in the chain by default
  localparam int unsigned DEFAULT_DEPTH = 64;

  // Source selection for the first stage
  typedef enum logic {
    SRC_EXT  = 1'b0,
    SRC_LOOP = 1'b1
  } src_sel_e;

endpackage

// File: rtl/recirc_rst_sync.sv
module recirc_rst_sync #(
  parameter int unsigned SYNC_LEN = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [SYNC_LEN-1:0] sync_q;
  logic [SYNC_LEN-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[SYNC_LEN-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[SYNC_LEN-1];

endmodule

// File: rtl/recirc_src_mux.sv
module recirc_src_mux
  import recirc_pkg::*;
(
  input  logic mode_sel,
  input  logic din_ext,
  input  logic din_loop,
  output logic sel_bit
);

  src_sel_e src;

  always_comb begin
    src = src_sel_e'(mode_sel);
    unique case (src)
      SRC_LOOP: sel_bit = din_loop;
      default:  sel_bit = din_ext;
    endcase
  end

endmodule

// File: rtl/recirc_cell.sv
module recirc_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic d,
  output logic q
);

  logic q_nxt;

  always_comb begin
    q_nxt = clr ? 1'b0 : d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= 1'b0;
    end else begin
      q <= q_nxt;
    end
  end

endmodule

// File: rtl/recirc_chain.sv
module recirc_chain #(
  parameter int unsigned DEPTH = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic sin,
  output logic head,
  output logic pre_tail,
  output logic tail
);

  localparam int unsigned LINKS = DEPTH + 1;

  logic [LINKS-1:0] link;

  assign link[0] = sin;

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    recirc_cell u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .d     (link[g]),
      .q     (link[g+1])
    );
  end

  assign head     = link[1];
  assign pre_tail = link[DEPTH-1];
  assign tail     = link[DEPTH];

endmodule

// File: rtl/recirc_half.sv
module recirc_half (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic d,
  output logic q
);

  logic q_nxt;

  always_comb begin
    q_nxt = clr ? 1'b0 : d;
  end

  // Captures on the falling edge, half a period after the chain moves
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= 1'b0;
    end else begin
      q <= q_nxt;
    end
  end

endmodule

// File: rtl/recirc_delay_reg.sv
module recirc_delay_reg
  import recirc_pkg::*;
#(
  parameter int unsigned DEPTH    = DEFAULT_DEPTH,
  parameter int unsigned SYNC_LEN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic mode_sel,
  input  logic din_ext,
  input  logic din_loop,
  output logic q_out,
  output logic q_out_n,
  output logic q_half,
  output logic clk_pass
);

  logic rst_sync_n;
  logic sel_bit;
  logic head;
  logic pre_tail;
  logic tail;

  recirc_rst_sync #(.SYNC_LEN(SYNC_LEN)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  recirc_src_mux u_mux (
    .mode_sel (mode_sel),
    .din_ext  (din_ext),
    .din_loop (din_loop),
    .sel_bit  (sel_bit)
  );

  recirc_chain #(.DEPTH(DEPTH)) u_chain (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clr      (clr),
    .sin      (sel_bit),
    .head     (head),
    .pre_tail (pre_tail),
    .tail     (tail)
  );

  recirc_half u_half (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (clr),
    .d     (tail),
    .q     (q_half)
  );

  assign q_out    = tail;
  assign q_out_n  = ~tail;
  assign clk_pass = clk;

endmodule

// File: rtl/recirc_delay_reg_chk.sv
module recirc_delay_reg_chk (
  input logic clk,
  input logic rst_n,
  input logic clr,
  input logic mode_sel,
  input logic din_ext,
  input logic din_loop,
  input logic head,
  input logic pre_tail,
  input logic q_out,
  input logic q_out_n,
  input logic q_half
);

  // R2: stage 1 takes the selected source
  p_src_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr) |-> head == ($past(mode_sel) ? $past(din_loop) : $past(din_ext)));

  // R1: the last stage takes what the stage before it held
  p_tail_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr) |-> q_out == $past(pre_tail));

  // R7: clear empties the chain on the next edge
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!q_out && !head));

  // R4: the half-stage matches the main output between falling and rising edges
  p_half_follow_r4: assert property (@(posedge clk) disable iff (!rst_n || clr)
    q_half == q_out);

  // R3: the inverse output never agrees with the true output
  p_inverse_r3: assert property (@(negedge clk) disable iff (!rst_n)
    q_out_n != q_out);

endmodule

bind recirc_delay_reg recirc_delay_reg_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .clr      (clr),
  .mode_sel (mode_sel),
  .din_ext  (din_ext),
  .din_loop (din_loop),
  .head     (head),
  .pre_tail (pre_tail),
  .q_out    (q_out),
  .q_out_n  (q_out_n),
  .q_half   (q_half)
);

// File: tb/recirc_delay_reg_tb.sv
module recirc_delay_reg_tb;

  localparam int D = 64;

  logic clk = 1'b0;
  bit   run = 1'b1;
  logic rst_n;
  logic clr;
  logic mode_sel;
  logic din_ext;
  logic loop_drv;
  bit   tie;
  logic din_loop;
  logic q_out, q_out_n, q_half, clk_pass;

  int n_chk = 0;
  int n_fail = 0;

  always begin
    #10;
    if (run) clk = ~clk;
  end

  assign din_loop = tie ? q_out : loop_drv;

  recirc_delay_reg u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .mode_sel (mode_sel),
    .din_ext  (din_ext),
    .din_loop (din_loop),
    .q_out    (q_out),
    .q_out_n  (q_out_n),
    .q_half   (q_half),
    .clk_pass (clk_pass)
  );

  // Behavioural reference: queue index 0 is stage 1, index D-1 the last stage
  bit mq[$];
  bit mhalf;

  always @(posedge clk or negedge rst_n) begin
    bit s;
    if (!rst_n) begin
      mq.delete();
      for (int i = 0; i < D; i++) mq.push_back(1'b0);
    end else begin
      s = mode_sel ? (tie ? mq[D-1] : loop_drv) : din_ext;
      if (clr) begin
        for (int i = 0; i < D; i++) mq[i] = 1'b0;
      end else begin
        mq.push_front(s);
        void'(mq.pop_back());
      end
    end
  end

  always @(negedge clk or negedge rst_n) begin
    if (!rst_n) mhalf = 1'b0;
    else        mhalf = clr ? 1'b0 : mq[D-1];
  end

  task automatic chk(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(string tag);
    @(posedge clk);
    #5;
    chk(tag, q_out, mq[D-1]);
    chk("R3", q_out_n, ~mq[D-1]);
    chk("R6", clk_pass, clk);
    @(negedge clk);
    #5;
    chk("R4", q_half, mhalf);
    chk("R6", clk_pass, clk);
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int first_hit;
    logic snap_q, snap_qn, snap_h;
    logic ring[D];

    rst_n = 1'b0; clr = 1'b0; mode_sel = 1'b0;
    din_ext = 1'b0; loop_drv = 1'b0; tie = 1'b0;
    #35;
    chk("R8", q_out, 1'b0);
    chk("R8", q_out_n, 1'b1);
    chk("R8", q_half, 1'b0);
    @(negedge clk); #5;
    rst_n = 1'b1;
    repeat (4) cyc("R8");

    // R1: single one travels the whole chain
    din_ext = 1'b1;
    cyc("R1");
    din_ext = 1'b0;
    first_hit = (q_out === 1'b1) ? 1 : 0;
    for (int k = 2; k <= 70; k++) begin
      cyc("R1");
      if (q_out === 1'b1 && first_hit == 0) first_hit = k;
    end
    chk("R1", (first_hit == 64), 1'b1);

    // R2: external source selected, loop input toggling
    mode_sel = 1'b0;
    for (int k = 0; k < 80; k++) begin
      din_ext  = ((k * 7) % 5) < 2;
      loop_drv = k[0];
      cyc("R2");
    end
    // R2: loop source selected, external input toggling
    mode_sel = 1'b1;
    for (int k = 0; k < 80; k++) begin
      loop_drv = ((k * 3) % 7) < 3;
      din_ext  = ~k[1];
      cyc("R2");
    end

    // R9: close the ring and check 64-edge periodicity
    tie = 1'b1;
    for (int k = 0; k < D; k++) begin
      din_ext = k[0];
      cyc("R9");
      ring[k] = q_out;
    end
    for (int k = 0; k < D; k++) begin
      din_ext = ~k[2];
      cyc("R9");
      chk("R9", q_out, ring[k]);
    end
    tie = 1'b0;

    // R5: clock parked high
    mode_sel = 1'b0;
    @(posedge clk); run = 1'b0; #5;
    snap_q = q_out; snap_qn = q_out_n; snap_h = q_half;
    din_ext = ~din_ext; mode_sel = 1'b1; loop_drv = ~loop_drv; #50;
    din_ext = ~din_ext; clr = 1'b1; #50;
    clr = 1'b0; #100;
    chk("R5", q_out, snap_q);
    chk("R5", q_out_n, snap_qn);
    chk("R5", q_half, snap_h);
    chk("R6", clk_pass, 1'b1);
    mode_sel = 1'b0; din_ext = 1'b1;
    run = 1'b1;
    @(negedge clk); #5;
    cyc("R5");
    // R5: clock parked low
    @(negedge clk); run = 1'b0; #5;
    snap_q = q_out; snap_qn = q_out_n; snap_h = q_half;
    din_ext = ~din_ext; mode_sel = 1'b1; loop_drv = ~loop_drv; #50;
    clr = 1'b1; #50;
    clr = 1'b0; #100;
    chk("R5", q_out, snap_q);
    chk("R5", q_out_n, snap_qn);
    chk("R5", q_half, snap_h);
    chk("R6", clk_pass, 1'b0);
    mode_sel = 1'b0; din_ext = 1'b1;
    run = 1'b1;
    cyc("R5");

    // R7: clear a chain full of ones while it shifts
    din_ext = 1'b1;
    repeat (70) cyc("R7");
    chk("R7", q_out, 1'b1);
    clr = 1'b1;
    cyc("R7");
    chk("R7", q_out, 1'b0);
    chk("R7", q_half, 1'b0);
    clr = 1'b0;
    repeat (10) cyc("R7");
    chk("R7", q_out, 1'b0);

    // R8: asynchronous reset in mid-run
    repeat (70) cyc("R8");
    chk("R8", q_out, 1'b1);
    rst_n = 1'b0; #3;
    chk("R8", q_out, 1'b0);
    chk("R8", q_half, 1'b0);
    @(negedge clk); #5;
    din_ext = 1'b0;
    rst_n = 1'b1;
    repeat (4) cyc("R8");
    din_ext = 1'b1;
    repeat (66) cyc("R8");

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule